// File: doc/BRIEF.md
# Character-Clock Skew Delay for Display Enable and Cursor

This block sits behind the timing counters of a CRT controller. It delays the display-enable (DE) and cursor strobes by zero, one or two character clocks. The delay matches the latency of the pixel path, which reads video RAM and then the character generator ROM before the pixel reaches the colour logic. Each strobe has its own two-bit delay field in the controller's 8-bit mode byte. A third two-bit field carries the interlace mode, which this block hands on untouched.

A delay field of zero routes the raw strobe straight to the output and holds that channel's delay stages at zero. If a nonzero delay is then selected while DE is active, the delayed DE stays low for the full programmed delay before it rises again. On screen this appears as a short stretch of border colour inside the active picture. The block keeps this effect on purpose.

Top module: `char_skew_delay`

## Requirements
- R1: While `rst_n` is low, `de_out` and `cur_out` are low whatever the strobe inputs, and every delay stage is cleared.
- R2: The DE delay field is `mode_reg[5:4]`. The value 00 passes `de_in` to `de_out` in the same cycle, with no register on the path.
- R3: A DE field of 01 makes `de_out` follow `de_in` one character clock later, so the value sampled at one rising edge appears after that edge.
- R4: A DE field of 10 makes `de_out` follow `de_in` two character clocks later.
- R5: A DE field of 11 holds `de_out` low.
- R6: The cursor delay field is `mode_reg[7:6]`. It uses the same encoding as R2 to R5, acts on `cur_in` and `cur_out`, and is independent of the DE field.
- R7: `ilace_mode` always equals `mode_reg[1:0]`, whatever the delay settings.
- R8: `mode_reg[3:2]` has no effect on either output.
- R9: A new value in a delay field takes effect at the next rising clock edge, not before.
- R10: When a delay field changes from 00 to 01 or 10 while its strobe is high, the output is low for exactly the programmed number of character clocks after the switching edge and then goes high. This holds because the stages were cleared while bypassed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de_in | input | 1 | Raw display-enable strobe from the timing counters |
| cur_in | input | 1 | Raw cursor strobe |
| mode_reg | input | 8 | Mode byte: [7:6] cursor delay, [5:4] DE delay, [3:2] unused, [1:0] interlace |
| de_out | output | 1 | Delayed display enable |
| cur_out | output | 1 | Delayed cursor strobe |
| ilace_mode | output | 2 | Interlace mode, passed through |

## Verification
The critical coincidence is a delay field leaving 00 in the same cycle that its strobe is high. The new setting has not taken effect at that moment. At the following edge the stages load from a cleared state while the raw input is still high. The bench provokes this by writing the mode byte in the middle of a DE-high run. It then requires the output to stay high until the switching edge, fall for exactly one or two character clocks (for a field of 01 or 10), and rise again. A second coincidence is DE and cursor pulsing together under different delay fields. Each output is judged against its own expected latency.

// File: rtl/char_skew_pkg.sv
package char_skew_pkg;

    // How a channel's output is produced for its current delay setting
    typedef enum logic [1:0] {
        TAP_PASS  = 2'd0,
        TAP_DELAY = 2'd1,
        TAP_MUTE  = 2'd2
    } tap_kind_e;

    // Field positions inside the mode byte
    localparam int MODE_W       = 8;
    localparam int FIELD_W      = 2;
    localparam int ILACE_LSB    = 0;
    localparam int DE_FIELD_LSB = 4;
    localparam int N_CHANNELS   = 2;

endpackage

// File: rtl/skew_sel_decode.sv
module skew_sel_decode
    import char_skew_pkg::*;
#(
    parameter int SEL_W      = 2,
    parameter int MAX_STAGES = 2,
    localparam int IDX_W     = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1
) (
    input  logic [SEL_W-1:0] sel,
    output tap_kind_e        kind,
    output logic [IDX_W-1:0] tap_idx
);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_STAGES);
    localparam logic [SEL_W-1:0] ONE_SEL = SEL_W'(1);

    always_comb begin
        tap_idx = '0;
        if (sel == '0) begin
            kind = TAP_PASS;
        end else if (sel <= MAX_SEL) begin
            kind    = TAP_DELAY;
            tap_idx = IDX_W'(sel - ONE_SEL);
        end else begin
            kind = TAP_MUTE;
        end
    end

endmodule

// File: rtl/skew_delay_line.sv
module skew_delay_line
    import char_skew_pkg::*;
#(
    parameter int SEL_W      = 2,
    parameter int MAX_STAGES = 2,
    localparam int IDX_W     = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             din,
    output logic             dout
);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_STAGES);

    typedef struct packed {
        logic [SEL_W-1:0]      sel;
        logic [MAX_STAGES-1:0] stg;
    } line_state_t;

    line_state_t st_d, st_q;
    tap_kind_e        kind_q;
    logic [IDX_W-1:0] idx_q;
    logic             bypass_q;

    skew_sel_decode #(
        .SEL_W      (SEL_W),
        .MAX_STAGES (MAX_STAGES)
    ) u_dec (
        .sel     (st_q.sel),
        .kind    (kind_q),
        .tap_idx (idx_q)
    );

    assign bypass_q = (kind_q == TAP_PASS);

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_in;
        for (int i = 0; i < MAX_STAGES; i++) begin
            if (bypass_q)
                st_d.stg[i] = 1'b0;
            else if (i == 0)
                st_d.stg[i] = din;
            else
                st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        dout = 1'b0;
        if (rst_n) begin
            case (kind_q)
                TAP_PASS:  dout = din;
                TAP_DELAY: dout = st_q.stg[idx_q];
                default:   dout = 1'b0;
            endcase
        end
    end

    // R10: a bypassed line holds its first stage cleared
    a_r10_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == '0) |=> (st_q.stg[0] == 1'b0));

    // R10: leaving bypass while the strobe is high gives a low output first
    a_r10_reenable_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == '0 && sel_in != '0 && sel_in <= MAX_SEL) |=> !dout);

    // R3: a steady one-stage setting repeats the previous input
    a_r3_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == SEL_W'(1) && sel_in == SEL_W'(1)) |=> (dout == $past(din)));

    // R5: a setting beyond the last stage mutes the output
    a_r5_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in > MAX_SEL) |=> !dout);

    generate
        if (MAX_STAGES >= 2) begin : g_two_stage_chk
            // R4: a steady two-stage setting repeats the input of two edges back
            a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.sel == SEL_W'(2) && sel_in == SEL_W'(2) && $past(st_q.sel) == SEL_W'(2))
                |=> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/char_skew_delay.sv
module char_skew_delay
    import char_skew_pkg::*;
#(
    parameter int MAX_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                de_in,
    input  logic                cur_in,
    input  logic [MODE_W-1:0]   mode_reg,
    output logic                de_out,
    output logic                cur_out,
    output logic [FIELD_W-1:0]  ilace_mode
);
    logic [N_CHANNELS-1:0] raw_vec;
    logic [N_CHANNELS-1:0] skew_vec;

    assign raw_vec = {cur_in, de_in};

    // Channel 0 is DE (bits 5:4), channel 1 is cursor (bits 7:6)
    generate
        for (genvar ch = 0; ch < N_CHANNELS; ch++) begin : g_chan
            skew_delay_line #(
                .SEL_W      (FIELD_W),
                .MAX_STAGES (MAX_STAGES)
            ) u_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel_in (mode_reg[DE_FIELD_LSB + ch*FIELD_W +: FIELD_W]),
                .din    (raw_vec[ch]),
                .dout   (skew_vec[ch])
            );
        end
    endgenerate

    assign de_out     = skew_vec[0];
    assign cur_out    = skew_vec[1];
    assign ilace_mode = mode_reg[ILACE_LSB +: FIELD_W];

    // R7: the interlace output only moves when its mode bits move
    a_r7_ilace_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_reg[ILACE_LSB +: FIELD_W]) |-> $stable(ilace_mode));

    // R1: outputs are low throughout reset
    always_comb begin
        if (!rst_n) a_r1_reset_low: assert (!de_out && !cur_out);
    end

endmodule

// File: tb/char_skew_delay_tb.sv
module char_skew_delay_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       de_in = 1'b0;
    logic       cur_in = 1'b0;
    logic [7:0] mode_reg = 8'h00;
    logic       de_out, cur_out;
    logic [1:0] ilace_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    char_skew_delay u_dut (
        .clk(clk), .rst_n(rst_n), .de_in(de_in), .cur_in(cur_in),
        .mode_reg(mode_reg), .de_out(de_out), .cur_out(cur_out),
        .ilace_mode(ilace_mode)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // drive strobes at the falling edge, sample 2 ns later
    task automatic cyc(input logic de, input logic cur);
        @(negedge clk);
        de_in = de; cur_in = cur;
        #2;
    endtask

    task automatic set_mode(input logic [7:0] m);
        @(negedge clk);
        mode_reg = m; de_in = 1'b0; cur_in = 1'b0;
        repeat (3) cyc(1'b0, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; de_in = 1'b1; cur_in = 1'b1; mode_reg = 8'h00;
        #2;
        chk("R1 de_out in reset", de_out, 1'b0);
        chk("R1 cur_out in reset", cur_out, 1'b0);
        @(negedge clk); rst_n = 1'b1; de_in = 1'b0; cur_in = 1'b0;
    endtask

    task automatic t_bypass;
        set_mode(8'h00);
        cyc(1'b1, 1'b0);
        chk("R2 bypass de high", de_out, 1'b1);
        cyc(1'b0, 1'b1);
        chk("R2 bypass de low", de_out, 1'b0);
        chk("R6 bypass cursor", cur_out, 1'b1);
    endtask

    task automatic t_one(input logic [7:0] m, input string req);
        set_mode(m);
        cyc(1'b1, 1'b0); chk(req, de_out, 1'b0);
        cyc(1'b0, 1'b0); chk(req, de_out, 1'b1);
        cyc(1'b0, 1'b0); chk(req, de_out, 1'b0);
    endtask

    task automatic t_two;
        set_mode(8'h20);
        cyc(1'b1, 1'b0); chk("R4 two d0", de_out, 1'b0);
        cyc(1'b0, 1'b0); chk("R4 two d1", de_out, 1'b0);
        cyc(1'b0, 1'b0); chk("R4 two d2", de_out, 1'b1);
        cyc(1'b0, 1'b0); chk("R4 two d3", de_out, 1'b0);
    endtask

    task automatic t_mute;
        set_mode(8'h30);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 1'b0); chk("R5 mute", de_out, 1'b0);
        end
    endtask

    task automatic t_cursor;
        set_mode(8'h40);
        cyc(1'b1, 1'b1); chk("R6 de bypass", de_out, 1'b1); chk("R6 cur d0", cur_out, 1'b0);
        cyc(1'b0, 1'b0); chk("R6 de low", de_out, 1'b0); chk("R6 cur d1", cur_out, 1'b1);
        set_mode(8'h90);
        cyc(1'b1, 1'b1); chk("R6 mix de d0", de_out, 1'b0); chk("R6 mix cur d0", cur_out, 1'b0);
        cyc(1'b0, 1'b0); chk("R6 mix de d1", de_out, 1'b1); chk("R6 mix cur d1", cur_out, 1'b0);
        cyc(1'b0, 1'b0); chk("R6 mix de d2", de_out, 1'b0); chk("R6 mix cur d2", cur_out, 1'b1);
        set_mode(8'hC0);
        cyc(1'b1, 1'b1); chk("R6 cur mute", cur_out, 1'b0); chk("R6 de bypass2", de_out, 1'b1);
        cyc(1'b1, 1'b1); chk("R6 cur mute2", cur_out, 1'b0);
    endtask

    task automatic t_ilace;
        logic [7:0] vals [4] = '{8'h00, 8'h31, 8'hE2, 8'h5F};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); mode_reg = vals[i]; #1;
            chk("R7 ilace", ilace_mode, vals[i][1:0]);
        end
    endtask

    task automatic t_unused;
        t_one(8'h1C, "R8 unused bits one-delay");
        set_mode(8'h0C);
        cyc(1'b1, 1'b1); chk("R8 unused bypass de", de_out, 1'b1); chk("R8 unused bypass cur", cur_out, 1'b1);
    endtask

    task automatic t_timing;
        set_mode(8'h00);
        cyc(1'b1, 1'b0);
        @(negedge clk); mode_reg = 8'h30; #2;
        chk("R9 before edge", de_out, 1'b1);
        cyc(1'b1, 1'b0); chk("R9 after edge", de_out, 1'b0);
    endtask

    task automatic t_reenable(input logic [7:0] m, input int n);
        set_mode(8'h00);
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        @(negedge clk); mode_reg = m; #2;
        chk("R10 still bypassed", de_out, 1'b1);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0); chk("R10 gap low", de_out, 1'b0);
        end
        cyc(1'b1, 1'b0); chk("R10 recovers", de_out, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20000 * 10);
        failures++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_bypass();
        t_one(8'h10, "R3 one-delay");
        t_two();
        t_mute();
        t_cursor();
        t_ilace();
        t_unused();
        t_timing();
        t_reenable(8'h10, 1);
        t_reenable(8'h20, 2);
        finish_run();
    end

endmodule